// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter/Receiver with Status Flags

This block is a register-mapped asynchronous serial port. Software sees two words: a data word and a status word. Writing the data word queues one byte for transmission. The transmit path has two stages. A holding register sits in front of a shift register, so a second byte can wait while the first is still on the line. The receive path keeps one byte. That byte stays until software reads it, and a byte that arrives before the read is flagged as an overrun.

Frames carry eight data bits, with no parity and one stop bit. The bit time is fixed at build time by two parameters: the clock divider and the oversampling factor. The receiver finds the middle of each bit from a 16x oversampling tick that it shares with the transmitter. Finished transmit frames and good received bytes raise a one-clock pulse on one line of an interrupt vector. The index of that line is a parameter and defaults to 3.

Top module: `uart_dbuf`

## Requirements
- R1: After reset, the status word reads 0x06, `txd` is high and every bit of `irq_lines` is low.
- R2: The data word is at offset 0x70 and the status word is at offset 0x74. Status bit 0 is receive-ready, bit 1 is shifter-empty, bit 2 is holding-empty and bit 4 is overrun. All other status bits read 0. A read of any other offset returns 0.
- R3: A frame is one low start bit, then eight data bits with the LSB first, then one high stop bit. Each bit lasts CLK_DIV*OVS clocks, and `txd` is high whenever the shifter is empty.
- R4: A data write while the shifter is empty starts a frame with that byte. Shifter-empty clears and holding-empty stays set.
- R5: A data write while the shifter is busy puts the byte in the holding register and clears holding-empty. Holding-empty is never clear while shifter-empty is set.
- R6: When a frame ends and a byte is held, that byte is sent next with no idle gap and holding-empty sets. When a frame ends and nothing is held, shifter-empty sets.
- R7: Each completed transmit frame gives exactly one one-clock pulse on `irq_lines[3]`. No other interrupt bit is ever driven.
- R8: A received byte with a good stop bit sets receive-ready and pulses `irq_lines[3]`. If receive-ready was already set, overrun also sets.
- R9: A read of the data word returns the most recently received byte in bits 7:0 and clears receive-ready.
- R10: A write of any value to the status word clears overrun.
- R11: A received frame whose stop bit is low is dropped: receive-ready is unchanged and no interrupt is raised. A low pulse on `rxd` that is shorter than half a bit does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, combinational while `bus_sel` is high and `bus_wr` is low |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line, asynchronous |
| irq_lines | output | IRQ_LINES | Interrupt vector; bit IRQ_LEVEL pulses for one clock |

## Verification
The bench builds the block with CLK_DIV=4 and OVS=16. One bit is then 64 clocks, so many whole frames in both directions fit in a short run. It uses the defaults IRQ_LEVEL=3 and SYNC_STAGES=2, and the bench checks the interrupt pulses on that line. With the short bit time the bench can also test the corner cases: the holding-to-shifter handoff, back-to-back overruns, frames with a low stop bit and sub-half-bit glitches on the receive line, all inside the cycle budget.

// File: rtl/uart_dbuf_pkg.sv
package uart_dbuf_pkg;
   // Status word bit positions; software decodes these.
   localparam int ST_RDY  = 0;
   localparam int ST_SEMP = 1;
   localparam int ST_HEMP = 2;
   localparam int ST_OVR  = 4;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_FRAME = 2'd1,
      RX_DRAIN = 2'd2
   } rx_state_e;
endpackage

// File: rtl/uart_dbuf_tick.sv
module uart_dbuf_tick #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   generate
      if (CLK_DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (cnt == CW'(CLK_DIV - 1)) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign tick = (cnt == CW'(CLK_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx #(
   parameter int OVS    = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_byte,
   output logic              txd,
   output logic              shift_empty,
   output logic              hold_empty,
   output logic              frame_done
);
   localparam int NBITS = DATA_W + 2;
   localparam int IW    = $clog2(NBITS);
   localparam int OW    = $clog2(OVS);

   logic              busy;
   logic              hempty;
   logic [DATA_W-1:0] hold;
   logic [NBITS-1:0]  frm;
   logic [IW-1:0]     idx;
   logic [OW-1:0]     ocnt;
   logic              bit_end;
   logic              last_bit;

   assign bit_end    = tick && (ocnt == OW'(OVS - 1));
   assign last_bit   = (idx == IW'(NBITS - 1));
   assign frame_done = busy && bit_end && last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         hempty <= 1'b1;
         hold   <= '0;
         frm    <= '1;
         idx    <= '0;
         ocnt   <= '0;
      end else if (!busy) begin
         if (wr_en) begin
            frm  <= {1'b1, wr_byte, 1'b0};
            busy <= 1'b1;
            idx  <= '0;
            ocnt <= '0;
         end
      end else begin
         if (wr_en) begin
            hold   <= wr_byte;
            hempty <= 1'b0;
         end
         if (tick) begin
            if (bit_end) begin
               ocnt <= '0;
               if (last_bit) begin
                  idx <= '0;
                  if (!hempty) begin
                     frm    <= {1'b1, hold, 1'b0};
                     hempty <= !wr_en;
                  end else if (wr_en) begin
                     frm    <= {1'b1, wr_byte, 1'b0};
                     hempty <= 1'b1;
                  end else begin
                     busy <= 1'b0;
                  end
               end else begin
                  idx <= idx + 1'b1;
               end
            end else begin
               ocnt <= ocnt + 1'b1;
            end
         end
      end
   end

   assign txd         = busy ? frm[idx] : 1'b1;
   assign shift_empty = !busy;
   assign hold_empty  = hempty;
endmodule

// File: rtl/uart_dbuf_rx.sv
module uart_dbuf_rx
   import uart_dbuf_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd_async,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_byte
);
   localparam int NBITS = DATA_W + 2;
   localparam int IW    = $clog2(NBITS);
   localparam int OW    = $clog2(OVS);

   logic rx_s;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         logic s0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s0 <= 1'b1;
            else        s0 <= rxd_async;
         end
         assign rx_s = s0;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] sq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq <= '1;
            else        sq <= {sq[SYNC_STAGES-2:0], rxd_async};
         end
         assign rx_s = sq[SYNC_STAGES-1];
      end
   endgenerate

   rx_state_e         st;
   logic [IW-1:0]     idx;
   logic [OW-1:0]     ocnt;
   logic [DATA_W-1:0] sh;
   logic              mid;

   assign mid = tick && (ocnt == OW'(OVS / 2 - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= RX_IDLE;
         idx      <= '0;
         ocnt     <= '0;
         sh       <= '0;
         rx_valid <= 1'b0;
         rx_byte  <= '0;
      end else begin
         rx_valid <= 1'b0;
         case (st)
            RX_IDLE: begin
               if (tick && !rx_s) begin
                  st   <= RX_FRAME;
                  idx  <= '0;
                  ocnt <= '0;
               end
            end
            RX_FRAME: begin
               if (tick) begin
                  if (ocnt == OW'(OVS - 1)) begin
                     ocnt <= '0;
                     idx  <= idx + 1'b1;
                  end else begin
                     ocnt <= ocnt + 1'b1;
                  end
               end
               if (mid) begin
                  if (idx == '0) begin
                     if (rx_s) st <= RX_IDLE;
                  end else if (idx == IW'(NBITS - 1)) begin
                     if (rx_s) begin
                        rx_valid <= 1'b1;
                        rx_byte  <= sh;
                        st       <= RX_IDLE;
                     end else begin
                        st <= RX_DRAIN;
                     end
                  end else begin
                     sh <= {rx_s, sh[DATA_W-1:1]};
                  end
               end
            end
            RX_DRAIN: begin
               if (rx_s) st <= RX_IDLE;
            end
            default: st <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_dbuf.sv
module uart_dbuf
   import uart_dbuf_pkg::*;
#(
   parameter int CLK_DIV     = 4,
   parameter int OVS         = 16,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int BUS_W       = 32,
   parameter int DATA_OFS    = 'h70,
   parameter int STAT_OFS    = 'h74,
   parameter int IRQ_LINES   = 16,
   parameter int IRQ_LEVEL   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              txd,
   input  logic              rxd,
   output logic [IRQ_LINES-1:0] irq_lines
);
   localparam logic [IRQ_LINES-1:0] IRQ_MASK = IRQ_LINES'(1) << IRQ_LEVEL;

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (DATA_W > BUS_W || BUS_W < 5) begin : g_bad_bus
         $error("BUS_W must hold the data byte and the status bits");
      end
      if (IRQ_LEVEL >= IRQ_LINES) begin : g_bad_irq
         $error("IRQ_LEVEL out of range");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (DATA_OFS == STAT_OFS || DATA_OFS >= (1 << ADDR_W) || STAT_OFS >= (1 << ADDR_W)) begin : g_bad_map
         $error("register offsets must differ and fit ADDR_W");
      end
      if (BUS_W > DATA_W) begin : g_wide
         logic wdata_unused;
         assign wdata_unused = ^bus_wdata[BUS_W-1:DATA_W];
      end
   endgenerate

   logic hit_data, hit_stat;
   logic wr_data, rd_data, wr_stat;

   assign hit_data = bus_sel && (bus_addr == ADDR_W'(DATA_OFS));
   assign hit_stat = bus_sel && (bus_addr == ADDR_W'(STAT_OFS));
   assign wr_data  = hit_data && bus_wr;
   assign rd_data  = hit_data && !bus_wr;
   assign wr_stat  = hit_stat && bus_wr;

   logic tick;
   logic tx_sre, tx_hre, tx_done;
   logic rx_valid;
   logic [DATA_W-1:0] rx_byte;

   uart_dbuf_tick #(.CLK_DIV(CLK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   uart_dbuf_tx #(.OVS(OVS), .DATA_W(DATA_W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .wr_en      (wr_data),
      .wr_byte    (bus_wdata[DATA_W-1:0]),
      .txd        (txd),
      .shift_empty(tx_sre),
      .hold_empty (tx_hre),
      .frame_done (tx_done)
   );

   uart_dbuf_rx #(.OVS(OVS), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .rxd_async(rxd),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte)
   );

   logic              rdy;
   logic              ovr;
   logic [DATA_W-1:0] rx_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy     <= 1'b0;
         ovr     <= 1'b0;
         rx_hold <= '0;
      end else begin
         if (rd_data)  rdy <= 1'b0;
         if (wr_stat)  ovr <= 1'b0;
         if (rx_valid) begin
            rx_hold <= rx_byte;
            rdy     <= 1'b1;
            if (rdy && !rd_data) ovr <= 1'b1;
         end
      end
   end

   logic [BUS_W-1:0] stat_word;

   always_comb begin
      stat_word          = '0;
      stat_word[ST_RDY]  = rdy;
      stat_word[ST_SEMP] = tx_sre;
      stat_word[ST_HEMP] = tx_hre;
      stat_word[ST_OVR]  = ovr;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         if (hit_data)      bus_rdata[DATA_W-1:0] = rx_hold;
         else if (hit_stat) bus_rdata = stat_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   irq_lines <= '0;
      else if (tx_done || rx_valid) irq_lines <= IRQ_MASK;
      else                          irq_lines <= '0;
   end
endmodule

// File: rtl/uart_dbuf_chk.sv
module uart_dbuf_chk #(
   parameter int IRQ_LINES = 16,
   parameter int IRQ_LEVEL = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_data,
   input logic                 rd_data,
   input logic                 wr_stat,
   input logic                 rx_valid,
   input logic                 sre,
   input logic                 hre,
   input logic                 rdy,
   input logic                 ovr,
   input logic                 txd,
   input logic [IRQ_LINES-1:0] irq_lines
);
   localparam logic [IRQ_LINES-1:0] OTHERS = ~(IRQ_LINES'(1) << IRQ_LEVEL);

   assert_idle_line_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sre |-> txd);

   assert_idle_write_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && sre) |=> (!sre && hre));

   assert_hold_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !hre |-> !sre);

   assert_irq_single_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_lines & OTHERS) == '0) && $onehot0(irq_lines));

   assert_overrun_with_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> rdy);

   assert_read_clears_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_valid) |=> !rdy);

   assert_stat_write_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !rx_valid) |=> !ovr);
endmodule

bind uart_dbuf uart_dbuf_chk #(.IRQ_LINES(IRQ_LINES), .IRQ_LEVEL(IRQ_LEVEL)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_data  (wr_data),
   .rd_data  (rd_data),
   .wr_stat  (wr_stat),
   .rx_valid (rx_valid),
   .sre      (tx_sre),
   .hre      (tx_hre),
   .rdy      (rdy),
   .ovr      (ovr),
   .txd      (txd),
   .irq_lines(irq_lines)
);

// File: tb/uart_dbuf_test.sv
module uart_dbuf_test;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_DIV    = 4;
   localparam int OVS        = 16;
   localparam int BIT        = CLK_DIV * OVS;
   localparam int WATCHDOG   = 150000;
   localparam logic [7:0] A_DATA = 8'h70;
   localparam logic [7:0] A_STAT = 8'h74;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        txd;
   logic        rxd = 1'b1;
   logic [15:0] irq_lines;

   int n_cmp = 0;
   int n_bad = 0;
   int irq_cnt = 0;
   int irq_other = 0;
   logic [7:0] exp_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   uart_dbuf #(.CLK_DIV(CLK_DIV), .OVS(OVS)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .txd(txd), .rxd(rxd), .irq_lines(irq_lines)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_status(input bit rdy, input bit semp,
                                              input bit hemp, input bit ovr);
      return {27'd0, ovr, 1'b0, hemp, semp, rdy};
   endfunction

   function automatic logic [9:0] frame_of(input logic [7:0] b, input bit stop);
      return {stop, b, 1'b0};
   endfunction

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic send_serial(input logic [7:0] b, input bit stop);
      logic [9:0] f;
      f = frame_of(b, stop);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         rxd = f[i];
         repeat (BIT - 1) @(negedge clk);
      end
      @(negedge clk);
      rxd = 1'b1;
      repeat (BIT) @(negedge clk);
   endtask

   task automatic wait_tx_idle();
      logic [31:0] s;
      s = '0;
      for (int k = 0; k < 4000; k++) begin
         bus_read(A_STAT, s);
         if (s[1] && s[2]) break;
      end
   endtask

   // Transmit line monitor: decodes frames at mid-bit
   initial begin
      logic [7:0] got;
      logic [7:0] want;
      forever begin
         @(negedge clk);
         if (rst_n && txd === 1'b0) begin
            repeat (BIT / 2) @(negedge clk);
            chk("R3 start bit low", {31'd0, txd}, 32'd0);
            for (int i = 0; i < 8; i++) begin
               repeat (BIT) @(negedge clk);
               got[i] = txd;
            end
            repeat (BIT) @(negedge clk);
            chk("R3 stop bit high", {31'd0, txd}, 32'd1);
            if (exp_q.size() == 0) begin
               chk("R3 unexpected frame", {24'd0, got}, 32'hFFFF_FFFF);
            end else begin
               want = exp_q.pop_front();
               chk("R3 R6 frame byte", {24'd0, got}, {24'd0, want});
            end
         end
      end
   end

   always @(negedge clk) begin
      if (irq_lines[3]) irq_cnt++;
      if ((irq_lines & ~16'h0008) != 16'h0) irq_other++;
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R3: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      logic [7:0]  b0, b1;
      int          base;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R2 reset state
      bus_read(A_STAT, r);
      chk("R1 reset status", r, exp_status(0, 1, 1, 0));
      chk("R1 txd idle", {31'd0, txd}, 32'd1);
      chk("R1 irq low", {16'd0, irq_lines}, 32'd0);
      bus_read(8'h78, r);
      chk("R2 unmapped offset reads zero", r, 32'd0);

      // R4 R5 R6 R7 directed handoff
      base = irq_cnt;
      exp_q.push_back(8'h55);
      bus_write(A_DATA, 32'h55);
      bus_read(A_STAT, r);
      chk("R4 shifter busy after idle write", r, exp_status(0, 0, 1, 0));
      exp_q.push_back(8'hA3);
      bus_write(A_DATA, 32'hA3);
      bus_read(A_STAT, r);
      chk("R5 holding full", r, exp_status(0, 0, 0, 0));
      repeat (10 * BIT + 10) @(negedge clk);
      bus_read(A_STAT, r);
      chk("R6 handoff holding empty, shifter busy", r, exp_status(0, 0, 1, 0));
      wait_tx_idle();
      bus_read(A_STAT, r);
      chk("R6 shifter empty after last frame", r, exp_status(0, 1, 1, 0));
      chk("R3 all frames seen", exp_q.size(), 32'd0);
      chk("R7 irq per tx frame", irq_cnt - base, 32'd2);

      // R3 R4 R6 random transmit
      for (int it = 0; it < 6; it++) begin
         base = irq_cnt;
         b0 = 8'($urandom);
         b1 = 8'($urandom);
         exp_q.push_back(b0);
         bus_write(A_DATA, {24'd0, b0});
         if (it % 2 == 1) begin
            exp_q.push_back(b1);
            bus_write(A_DATA, {24'd0, b1});
         end
         wait_tx_idle();
         repeat (4) @(negedge clk);
         chk("R3 random frames drained", exp_q.size(), 32'd0);
         chk("R7 random irq count", irq_cnt - base, (it % 2 == 1) ? 32'd2 : 32'd1);
      end
      bus_write(A_DATA, 32'hFFFF_FF0F);
      exp_q.push_back(8'h0F);
      wait_tx_idle();
      chk("R3 upper write bits ignored", exp_q.size(), 32'd0);

      // R8 R9 receive
      for (int it = 0; it < 5; it++) begin
         base = irq_cnt;
         b0 = (it == 0) ? 8'h3C : 8'($urandom);
         send_serial(b0, 1'b1);
         bus_read(A_STAT, r);
         chk("R8 ready set after rx", r, exp_status(1, 1, 1, 0));
         chk("R8 rx irq", irq_cnt - base, 32'd1);
         bus_read(A_DATA, r);
         chk("R9 rx byte", r, {24'd0, b0});
         bus_read(A_STAT, r);
         chk("R9 ready cleared by read", r, exp_status(0, 1, 1, 0));
      end

      // R8 R10 overrun
      b0 = 8'($urandom);
      b1 = 8'h81;
      send_serial(b0, 1'b1);
      send_serial(b1, 1'b1);
      bus_read(A_STAT, r);
      chk("R8 overrun set", r, exp_status(1, 1, 1, 1));
      bus_read(A_DATA, r);
      chk("R9 latest byte after overrun", r, {24'd0, b1});
      bus_read(A_STAT, r);
      chk("R9 ready clear, overrun kept", r, exp_status(0, 1, 1, 1));
      bus_write(A_STAT, 32'h0);
      bus_read(A_STAT, r);
      chk("R10 status write clears overrun", r, exp_status(0, 1, 1, 0));

      // R11 bad stop bit and short glitch
      base = irq_cnt;
      send_serial(8'h99, 1'b0);
      bus_read(A_STAT, r);
      chk("R11 bad stop dropped", r, exp_status(0, 1, 1, 0));
      chk("R11 no irq on bad stop", irq_cnt - base, 32'd0);
      @(negedge clk);
      rxd = 1'b0;
      repeat (10) @(negedge clk);
      rxd = 1'b1;
      repeat (2 * BIT) @(negedge clk);
      bus_read(A_STAT, r);
      chk("R11 glitch ignored", r, exp_status(0, 1, 1, 0));
      chk("R11 no irq on glitch", irq_cnt - base, 32'd0);
      send_serial(8'hC6, 1'b1);
      bus_read(A_DATA, r);
      chk("R11 recovers after bad frame", r, 32'h0000_00C6);

      chk("R7 no other irq line", irq_other, 32'd0);
      finish_run();
   end
endmodule